// File: doc/BRIEF.md
# Dual Watchpoint Comparator with Range Chaining

This block holds two debug watchpoint units that examine every bus access. Each unit keeps a value register and a mask register for the address, for the data and for a condition word. Every bit of the address, data and bus control is compared for equality with its value bit. A mask bit of 1 turns that bit into a don't-care. When all address bits, all data bits and all eight bus control bits pass, the unit raises its range signal in the same cycle.

The condition word carries three more bits beyond the bus control byte. One is a range condition: unit 1's range signal feeds unit 0's range condition. Unit 0 can be programmed to expect that input high or low. Expecting it low gives a breakpoint that fires inside a large power-of-two region but outside a smaller one nested in it. Unit 1 can be left disabled, so it serves only as the range source. The other two condition bits compare against two external debug inputs, which are sampled on the rising clock edge.

A unit takes part in the breakpoint output only when its enable bit is set. The breakpoint output is registered. Registers are written one word at a time through a select-based write port.

Top module: `wp_pair`

## Requirements
- R1: `rng_out[u]` is high in the same cycle as the access exactly when every bit of `bus_addr`, `bus_data` and `bus_ctl[7:0]` equals the matching value bit of unit u, or has its mask bit set.
- R2: A mask bit of 1 makes the matching bus bit a don't-care. With every address, data and bus-control mask bit set, `rng_out[u]` is high whatever the bus carries.
- R3: Condition bit 8 of unit 0 compares against `rng_out[1]`. Unit 1's bit 8 compares against constant 0. A set mask bit 8 ignores the comparison.
- R4: Unit 1 drives `rng_out[1]` while its enable bit is clear. In that state it contributes no breakpoint.
- R5: Take unit 1 with address value 0 and mask 0x1F, disabled. Take unit 0 with address value 0 and mask 0xFF, enabled, with condition bit 8 value 0 and mask 0. Then a breakpoint occurs for addresses 0x20 to 0xFF and not for 0x00 to 0x1F or 0x100.
- R6: `dbg_ext[1:0]` is sampled on the rising clock edge. Condition bits 10:9 compare against the sampled value, so an input level affects `bkpt_hit` two edges after it is applied.
- R7: `bkpt_hit` is high in the cycle after an access exactly when some unit had its enable bit set and passed R1 together with condition bits 10:8.
- R8: A write with `wr_en` high lands at the next rising edge in unit `wr_unit`. `wr_sel` picks the target: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 condition value, 5 condition mask, 6 enable (bit 0). Select 7 changes nothing.
- R9: Reset (`rst_n` low) clears every value register and the enable bits, and sets every mask bit. After reset `rng_out` is 2'b11 and `bkpt_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Unit addressed by the write |
| wr_sel | input | 3 | Register select within the unit |
| wr_data | input | 32 | Write data |
| bus_addr | input | 32 | Access address |
| bus_data | input | 32 | Access data |
| bus_ctl | input | 8 | Access control bits |
| dbg_ext | input | 2 | External debug conditions |
| rng_out | output | 2 | Per-unit range signal |
| bkpt_hit | output | 1 | Registered breakpoint |

## Verification
A corrupted value or mask register shows at once: `rng_out` takes the wrong level in the very next cycle whose bus bits touch the damaged bit. A broken chain or a wrong range expectation shows only on `bkpt_hit`, one edge after the access. A stale external sample shows there one edge later still. The reference model recomputes both outputs each cycle, so any such fault shows up in the first cycle whose stimulus exposes it.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int BUS_CTL_W = 8;
    localparam int ADDR_CTL_W = 5;
    localparam int EXT_W     = 2;
    localparam int COND_W    = BUS_CTL_W + 1 + EXT_W;
    localparam int RANGE_BIT = BUS_CTL_W;
    localparam int WR_W      = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

    typedef enum logic [2:0] {
        SEL_AVAL = 3'd0,
        SEL_AMSK = 3'd1,
        SEL_DVAL = 3'd2,
        SEL_DMSK = 3'd3,
        SEL_CVAL = 3'd4,
        SEL_CMSK = 3'd5,
        SEL_CFG  = 3'd6,
        SEL_NONE = 3'd7
    } wp_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] av;
        logic [ADDR_W-1:0] am;
        logic [DATA_W-1:0] dv;
        logic [DATA_W-1:0] dm;
        logic [COND_W-1:0] cv;
        logic [COND_W-1:0] cm;
        logic              en;
    } wp_regs_t;
endpackage

// File: rtl/wp_regs.sv
module wp_regs
    import wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [2:0]      wr_sel,
    input  logic [WR_W-1:0] wr_data,
    output wp_regs_t        regs
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs.av <= '0;
            regs.am <= '1;
            regs.dv <= '0;
            regs.dm <= '1;
            regs.cv <= '0;
            regs.cm <= '1;
            regs.en <= 1'b0;
        end else if (wr_hit) begin
            case (wp_sel_e'(wr_sel))
                SEL_AVAL: regs.av <= wr_data[ADDR_W-1:0];
                SEL_AMSK: regs.am <= wr_data[ADDR_W-1:0];
                SEL_DVAL: regs.dv <= wr_data[DATA_W-1:0];
                SEL_DMSK: regs.dm <= wr_data[DATA_W-1:0];
                SEL_CVAL: regs.cv <= wr_data[COND_W-1:0];
                SEL_CMSK: regs.cm <= wr_data[COND_W-1:0];
                SEL_CFG:  regs.en <= wr_data[0];
                default:  ;
            endcase
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_sel == SEL_AVAL) |=> (regs.av == $past(wr_data[ADDR_W-1:0]))); // R8
    AST_IDLE_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_sel == SEL_NONE) |=> $stable(regs)); // R8
endmodule

// File: rtl/wp_cmp.sv
module wp_cmp
    import wp_pkg::*;
(
    input  wp_regs_t             regs,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    input  logic [BUS_CTL_W-1:0] bus_ctl,
    input  logic                 range_in,
    input  logic [EXT_W-1:0]     ext_q,
    output logic                 rng,
    output logic                 full
);
    localparam int HI_W = COND_W - BUS_CTL_W;

    logic            addr_ok, data_ok, ctl_lo_ok, ctl_hi_ok, cond_ok;
    logic [HI_W-1:0] cond_hi;

    always_comb begin
        addr_ok   = &(~(regs.av ^ bus_addr) | regs.am);
        data_ok   = &(~(regs.dv ^ bus_data) | regs.dm);
        ctl_lo_ok = &(~(regs.cv[ADDR_CTL_W-1:0] ^ bus_ctl[ADDR_CTL_W-1:0])
                      | regs.cm[ADDR_CTL_W-1:0]);
        ctl_hi_ok = &(~(regs.cv[BUS_CTL_W-1:ADDR_CTL_W] ^ bus_ctl[BUS_CTL_W-1:ADDR_CTL_W])
                      | regs.cm[BUS_CTL_W-1:ADDR_CTL_W]);
        cond_hi   = {ext_q, range_in};
        cond_ok   = &(~(regs.cv[COND_W-1:BUS_CTL_W] ^ cond_hi) | regs.cm[COND_W-1:BUS_CTL_W]);
        rng       = addr_ok && ctl_lo_ok && data_ok && ctl_hi_ok;
        full      = rng && cond_ok;
    end

    always_comb begin
        if (&regs.am && &regs.dm && &regs.cm[BUS_CTL_W-1:0]) begin
            AST_ALL_MASKED_RNG: assert (rng); // R2
        end
    end
endmodule

// File: rtl/wp_pair.sv
module wp_pair
    import wp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_unit,
    input  logic [2:0]           wr_sel,
    input  logic [WR_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    input  logic [BUS_CTL_W-1:0] bus_ctl,
    input  logic [EXT_W-1:0]     dbg_ext,
    output logic [1:0]           rng_out,
    output logic                 bkpt_hit
);
    localparam int N_UNITS = 2;

    logic [EXT_W-1:0]   ext_q;
    logic [N_UNITS-1:0] rng_core, full_core, en_vec, rin;

    assign rin = {1'b0, rng_core[1]};

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        wp_regs_t regs;

        wp_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_en && (wr_unit == 1'(u))),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .regs    (regs)
        );

        wp_cmp u_cmp (
            .regs     (regs),
            .bus_addr (bus_addr),
            .bus_data (bus_data),
            .bus_ctl  (bus_ctl),
            .range_in (rin[u]),
            .ext_q    (ext_q),
            .rng      (rng_core[u]),
            .full     (full_core[u])
        );

        assign en_vec[u] = regs.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q    <= '0;
            bkpt_hit <= 1'b0;
        end else begin
            ext_q    <= dbg_ext;
            bkpt_hit <= |(en_vec & full_core);
        end
    end

    assign rng_out = rng_core;

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit |-> $past(|en_vec)); // R7
    AST_HIT_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit |-> $past(|(rng_out & en_vec))); // R7
    AST_DISABLED_U1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_vec[0] && !en_vec[1]) |=> !bkpt_hit); // R4
endmodule

// File: tb/tb_wp_pair.sv
module tb_wp_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_unit = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [7:0]  bus_ctl = '0;
    logic [1:0]  dbg_ext = '0;
    logic [1:0]  rng_out;
    logic        bkpt_hit;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R9";

    always #5 clk = ~clk;

    wp_pair dut (.*);

    // behavioural reference model
    logic [31:0] m_av [2], m_am [2], m_dv [2], m_dm [2];
    logic [10:0] m_cv [2], m_cm [2];
    logic        m_en [2];
    logic [1:0]  m_ext;
    logic        m_hit;

    function automatic bit fld_ok(logic [31:0] v, logic [31:0] m, logic [31:0] x, int w);
        for (int i = 0; i < w; i++)
            if (!m[i] && v[i] !== x[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_rng(int u);
        return fld_ok(m_av[u], m_am[u], bus_addr, 32) && fld_ok(m_dv[u], m_dm[u], bus_data, 32)
            && fld_ok(32'(m_cv[u]), 32'(m_cm[u]), 32'(bus_ctl), 8);
    endfunction

    function automatic bit m_full(int u);
        bit rin;
        rin = (u == 0) ? m_rng(1) : 1'b0;
        return m_rng(u) && (m_cm[u][8] || m_cv[u][8] == rin)
            && (m_cm[u][9] || m_cv[u][9] == m_ext[0])
            && (m_cm[u][10] || m_cv[u][10] == m_ext[1]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < 2; u++) begin
                m_av[u] = '0; m_am[u] = '1; m_dv[u] = '0; m_dm[u] = '1;
                m_cv[u] = '0; m_cm[u] = '1; m_en[u] = 1'b0;
            end
            m_ext = '0;
            m_hit = 1'b0;
        end else begin
            m_hit = (m_en[0] && m_full(0)) || (m_en[1] && m_full(1));
            m_ext = dbg_ext;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_av[wr_unit] = wr_data;
                    3'd1: m_am[wr_unit] = wr_data;
                    3'd2: m_dv[wr_unit] = wr_data;
                    3'd3: m_dm[wr_unit] = wr_data;
                    3'd4: m_cv[wr_unit] = wr_data[10:0];
                    3'd5: m_cm[wr_unit] = wr_data[10:0];
                    3'd6: m_en[wr_unit] = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic compare();
        logic [1:0] exp_rng;
        exp_rng = {m_rng(1), m_rng(0)};
        n_cmp++;
        if (rng_out !== exp_rng) begin
            n_bad++;
            $display("FAIL %s rng_out actual %b expected %b addr %h", cur_tag, rng_out, exp_rng, bus_addr);
        end
        n_cmp++;
        if (bkpt_hit !== m_hit) begin
            n_bad++;
            $display("FAIL %s bkpt_hit actual %b expected %b addr %h", cur_tag, bkpt_hit, m_hit, bus_addr);
        end
    endtask

    // compare the previous cycle, then drive the next one
    task automatic step(string tag, logic we, logic wu, logic [2:0] ws, logic [31:0] wd,
                        logic [31:0] a, logic [31:0] d, logic [7:0] c, logic [1:0] e);
        @(negedge clk);
        compare();
        cur_tag = tag;
        wr_en = we; wr_unit = wu; wr_sel = ws; wr_data = wd;
        bus_addr = a; bus_data = d; bus_ctl = c; dbg_ext = e;
    endtask

    task automatic wr(string tag, logic u, logic [2:0] s, logic [31:0] v);
        step(tag, 1'b1, u, s, v, 32'h0, 32'h0, 8'h0, 2'b00);
    endtask

    task automatic acc(string tag, logic [31:0] a, logic [31:0] d, logic [7:0] c, logic [1:0] e);
        step(tag, 1'b0, 1'b0, 3'd0, 32'h0, a, d, c, e);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state observed on the first compare
        acc("R9", 32'hDEAD_BEEF, 32'h1234_5678, 8'hA5, 2'b00);
        acc("R9", 32'h0, 32'h0, 8'h00, 2'b00);
        // R1 R2 R8: unit 0 exact address
        wr("R8", 1'b0, 3'd0, 32'h0000_1000);
        wr("R8", 1'b0, 3'd1, 32'h0000_0000);
        acc("R1", 32'h0000_1000, 32'h0, 8'h00, 2'b00);
        acc("R1", 32'h0000_1004, 32'h0, 8'h00, 2'b00);
        acc("R2", 32'h0000_1000, 32'hFFFF_FFFF, 8'hFF, 2'b00);
        // R7: enable unit 0, hit appears one cycle after the access
        wr("R7", 1'b0, 3'd6, 32'h1);
        acc("R7", 32'h0000_1000, 32'h0, 8'h00, 2'b00);
        acc("R7", 32'h0000_2000, 32'h0, 8'h00, 2'b00);
        acc("R7", 32'h0000_1000, 32'h0, 8'h00, 2'b00);
        // R1: data low byte and control bits 7:5
        wr("R1", 1'b0, 3'd2, 32'h0000_00C3);
        wr("R1", 1'b0, 3'd3, 32'hFFFF_FF00);
        wr("R1", 1'b0, 3'd4, 32'h0000_00A0);
        wr("R1", 1'b0, 3'd5, 32'h0000_071F);
        acc("R1", 32'h0000_1000, 32'h5555_55C3, 8'hA7, 2'b00);
        acc("R1", 32'h0000_1000, 32'h5555_55C2, 8'hA7, 2'b00);
        acc("R1", 32'h0000_1000, 32'h5555_55C3, 8'h87, 2'b00);
        acc("R2", 32'h0000_1000, 32'h0000_00C3, 8'hBF, 2'b00);
        // R8: select 7 changes nothing
        wr("R8", 1'b0, 3'd7, 32'hFFFF_FFFF);
        acc("R8", 32'h0000_1000, 32'h0000_00C3, 8'hA0, 2'b00);
        acc("R8", 32'hFFFF_FFFF, 32'h0000_00C3, 8'hA0, 2'b00);
        // R5 R3 R4: range pair
        wr("R5", 1'b0, 3'd3, 32'hFFFF_FFFF);
        wr("R5", 1'b0, 3'd4, 32'h0000_0000);
        wr("R5", 1'b0, 3'd5, 32'h0000_06FF);
        wr("R5", 1'b0, 3'd1, 32'h0000_00FF);
        wr("R5", 1'b0, 3'd0, 32'h0000_0000);
        wr("R4", 1'b1, 3'd0, 32'h0000_0000);
        wr("R4", 1'b1, 3'd1, 32'h0000_001F);
        for (int k = 0; k < 4; k++) begin
            acc("R5", 32'h0000_0000, 32'h0, 8'h00, 2'b00);
            acc("R5", 32'h0000_0010, 32'h0, 8'h00, 2'b00);
            acc("R5", 32'h0000_0020, 32'h0, 8'h00, 2'b00);
            acc("R5", 32'h0000_00FF, 32'h0, 8'h00, 2'b00);
            acc("R5", 32'h0000_0100, 32'h0, 8'h00, 2'b00);
            acc("R4", 32'h0000_001F, 32'h0, 8'h00, 2'b00);
        end
        // R3: expect range input high instead
        wr("R3", 1'b0, 3'd4, 32'h0000_0100);
        acc("R3", 32'h0000_0008, 32'h0, 8'h00, 2'b00);
        acc("R3", 32'h0000_0040, 32'h0, 8'h00, 2'b00);
        // R3: unit 1 enabled, its own range bit expects 0
        wr("R3", 1'b1, 3'd5, 32'h0000_06FF);
        wr("R3", 1'b1, 3'd6, 32'h1);
        acc("R3", 32'h0000_0004, 32'h0, 8'h00, 2'b00);
        acc("R3", 32'h0000_0400, 32'h0, 8'h00, 2'b00);
        wr("R3", 1'b1, 3'd6, 32'h0);
        wr("R3", 1'b0, 3'd5, 32'h0000_07FF);
        // R6: unit 0 requires sampled dbg_ext[0] high
        wr("R6", 1'b0, 3'd4, 32'h0000_0200);
        wr("R6", 1'b0, 3'd5, 32'h0000_05FF);
        acc("R6", 32'h0000_0040, 32'h0, 8'h00, 2'b01);
        acc("R6", 32'h0000_0040, 32'h0, 8'h00, 2'b00);
        acc("R6", 32'h0000_0040, 32'h0, 8'h00, 2'b00);
        acc("R6", 32'h0000_0040, 32'h0, 8'h00, 2'b11);
        acc("R6", 32'h0000_0040, 32'h0, 8'h00, 2'b11);
        acc("R6", 32'h0000_0300, 32'h0, 8'h00, 2'b11);
        // R9: reset mid-run returns the default state
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R9";
        acc("R9", 32'h0000_0040, 32'h0, 8'h00, 2'b11);
        acc("R9", 32'h0000_0040, 32'h0, 8'h00, 2'b00);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule